// File: doc/BRIEF.md
# Interrupt Status and Enable Register

A single 32-bit register that gathers interrupt events from an acquisition front end and presents them to software over a simple write port with a read-data output. Nine sources feed it: two external inputs, a DAC load input, a FIFO overrun condition, a FIFO almost-full condition, a DMA timeout, a DMA completion, an ADC start input and an ADC trigger input. Each source has a status bit that latches when its event occurs and an enable bit that lets the status drive the interrupt line.

Status and enables share one word. The status bits are write-one-to-clear and the enables are plain read/write, so software can read the register and write the same value back. That one write acknowledges every pending event and leaves the mask as it was. Bit 31 latches a watchdog timeout. The FIFO conditions come from the FIFO fill count, the programmed threshold, the push strobe and the full flag. The other sources arrive as single-cycle pulses.

Top module: `irq_stat_en_reg`

## Requirements
- R1: After reset, every bit of `rd_data` is 0 and `irq` is low.
- R2: Source index i has its status bit at position 16+i and its enable at position i. The index map is: 0 ADC trigger, 1 ADC start, 2 DMA done, 3 DMA timeout, 4 FIFO almost full, 5 FIFO overrun, 6 DAC load, 7 `ext_ev[0]`, 8 `ext_ev[1]`. An event sets its status bit on the next clock edge.
- R3: A write of 1 to status bit 16+i clears that bit on the write's clock edge. A write of 0 to it leaves the bit unchanged.
- R4: Writing back the value just read clears every pending status bit, including bit 31, and leaves the enables unchanged.
- R5: When an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R6: Status bit 20 sets in any cycle in which `fifo_count` >= `fifo_thresh`. Status bit 21 sets in any cycle in which `fifo_push` and `fifo_full` are both high.
- R7: A write takes effect only when all four bits of `wr_be` are 1. Any other byte-enable pattern leaves the register unchanged.
- R8: `irq` is high exactly when some status bit 16+i and its enable bit i are both 1. It follows the register state in the same cycle, so it falls right after the edge that clears the last enabled pending bit.
- R9: Bit 31 latches on a `wdog_bark` pulse, clears when a 1 is written to it, and has no effect on `irq`.
- R10: Bits 30:25 and 15:9 always read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| adc_trig_ev | input | 1 | ADC trigger event pulse (index 0) |
| adc_start_ev | input | 1 | ADC start event pulse (index 1) |
| dma_done_ev | input | 1 | DMA done event pulse (index 2) |
| dma_timeout_ev | input | 1 | DMA timeout event pulse (index 3) |
| fifo_count | input | CNT_W | FIFO fill count |
| fifo_thresh | input | CNT_W | Almost-full threshold |
| fifo_push | input | 1 | FIFO write strobe |
| fifo_full | input | 1 | FIFO full flag |
| dac_load_ev | input | 1 | DAC load event pulse (index 6) |
| ext_ev | input | 2 | External event pulses (indices 7, 8) |
| wdog_bark | input | 1 | Watchdog timeout pulse |
| irq | output | 1 | Interrupt request |

## Verification
Register state changes on the clock edge at which an event or a qualified write is presented, and `rd_data` and `irq` show the new state straight after that edge. There is no further pipeline stage. The bench drives inputs on the falling edge and lets a behavioural model take the same inputs on the rising edge. It then compares `rd_data` and `irq` with the model on the next falling edge, one cycle after the stimulus. Directed phases cover the same-edge conflict between an event and a clearing write, partial-byte writes, and the write-back acknowledge. A randomized phase follows them.

// File: rtl/irq_stat_en_reg.sv
module irq_stat_en_reg #(
  parameter int CNT_W = 16,
  parameter int NSRC  = 9,
  parameter int STAT_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             adc_trig_ev,
  input  logic             adc_start_ev,
  input  logic             dma_done_ev,
  input  logic             dma_timeout_ev,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] fifo_thresh,
  input  logic             fifo_push,
  input  logic             fifo_full,
  input  logic             dac_load_ev,
  input  logic [1:0]       ext_ev,
  input  logic             wdog_bark,
  output logic             irq
);
  localparam int STAT_MSB = STAT_LSB + NSRC - 1;

  logic [NSRC-1:0] stat, en, ev, clr;
  logic            wdg, wr_ok;

  assign ev = {ext_ev[1], ext_ev[0], dac_load_ev,
               fifo_push & fifo_full,
               fifo_count >= fifo_thresh,
               dma_timeout_ev, dma_done_ev, adc_start_ev, adc_trig_ev};

  assign wr_ok = wr_en && (wr_be == 4'hF);
  assign clr   = wr_ok ? wr_data[STAT_MSB:STAT_LSB] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      wdg  <= 1'b0;
    end else begin
      stat <= (stat & ~clr) | ev;
      if (wr_ok) en <= wr_data[NSRC-1:0];
      wdg  <= wdog_bark | (wdg & ~(wr_ok & wr_data[31]));
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[31] = wdg;
    rd_data[STAT_MSB:STAT_LSB] = stat;
    rd_data[NSRC-1:0] = en;
  end

  assign irq = |(stat & en);

  // R2: an event sets its status bit on the next edge
  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    |ev |=> ((rd_data[STAT_MSB:STAT_LSB] & $past(ev)) == $past(ev)));

  // R3: a clearing write without a colliding event drops the bit
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> ((rd_data[STAT_MSB:STAT_LSB] &
                $past(wr_data[STAT_MSB:STAT_LSB] & ~ev)) == '0));

  // R3: a zero written to a set bit keeps it
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> ((rd_data[STAT_MSB:STAT_LSB] &
                $past(stat & ~wr_data[STAT_MSB:STAT_LSB])) ==
               $past(stat & ~wr_data[STAT_MSB:STAT_LSB])));

  // R7: partial byte enables change nothing
  a_r7_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be != 4'hF && ev == '0 && !wdog_bark) |=> $stable(rd_data));

  // R8: the interrupt line holds while the register holds
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev == '0) |=> $stable(irq));

  // R9: the watchdog flag stays until a clearing write
  a_r9_wdg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && !(wr_ok && wr_data[31])) |=> rd_data[31]);
endmodule

// File: tb/sim_irq_stat_en_reg.sv
module sim_irq_stat_en_reg;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [3:0] wr_be = 0; logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic adc_trig_ev = 0, adc_start_ev = 0, dma_done_ev = 0, dma_timeout_ev = 0;
  logic [CNT_W-1:0] fifo_count = 0, fifo_thresh = 16'hFFFF;
  logic fifo_push = 0, fifo_full = 0, dac_load_ev = 0, wdog_bark = 0, irq;
  logic [1:0] ext_ev = 0;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  logic [8:0] m_stat = 0, m_en = 0;
  logic m_wdg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stat_en_reg #(.CNT_W(CNT_W)) u0 (.*);

  // behavioural reference
  always @(posedge clk) begin
    bit hit[9];
    bit full_wr;
    hit[0] = adc_trig_ev; hit[1] = adc_start_ev; hit[2] = dma_done_ev;
    hit[3] = dma_timeout_ev; hit[4] = (fifo_count >= fifo_thresh);
    hit[5] = fifo_push && fifo_full; hit[6] = dac_load_ev;
    hit[7] = ext_ev[0]; hit[8] = ext_ev[1];
    full_wr = wr_en && (wr_be == 4'b1111);
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_wdg = 0;
    end else begin
      for (int i = 0; i < 9; i++)
        if (hit[i]) m_stat[i] = 1'b1;
        else if (full_wr && wr_data[16+i]) m_stat[i] = 1'b0;
      if (full_wr) m_en = wr_data[8:0];
      if (wdog_bark) m_wdg = 1'b1;
      else if (full_wr && wr_data[31]) m_wdg = 1'b0;
    end
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w = 0;
    w[31] = m_wdg;
    for (int i = 0; i < 9; i++) begin
      w[16+i] = m_stat[i];
      w[i] = m_en[i];
    end
    return w;
  endfunction

  function automatic logic exp_irq();
    logic r = 0;
    for (int i = 0; i < 9; i++) if (m_stat[i] && m_en[i]) r = 1;
    return r;
  endfunction

  task automatic compare();
    vectors++;
    if (rd_data !== exp_word()) begin
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, exp_word());
    end
    if (irq !== exp_irq()) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, exp_irq());
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_be = 0; wr_data = 0;
    {adc_trig_ev, adc_start_ev, dma_done_ev, dma_timeout_ev} = 0;
    fifo_push = 0; fifo_full = 0; fifo_count = 0; fifo_thresh = 16'hFFFF;
    dac_load_ev = 0; ext_ev = 0; wdog_bark = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic pulse(input int idx);
    case (idx)
      0: adc_trig_ev = 1; 1: adc_start_ev = 1; 2: dma_done_ev = 1;
      3: dma_timeout_ev = 1;
      4: begin fifo_count = 16'd40; fifo_thresh = 16'd40; end
      5: begin fifo_push = 1; fifo_full = 1; end
      6: dac_load_ev = 1; 7: ext_ev[0] = 1; default: ext_ev[1] = 1;
    endcase
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be = 4'hF);
    wr_en = 1; wr_be = be; wr_data = d;
  endtask

  initial begin
    idle();
    cur_req = "R1";
    repeat (3) step();
    rst_n = 1;
    step();

    cur_req = "R2";
    for (int i = 0; i < 9; i++) begin pulse(i); step(); end
    step();

    cur_req = "R8";
    wr(32'h0000_0005); step();
    wr(32'h0005_0000); step();
    step();
    wr(32'h0001_0000); step();
    step();

    cur_req = "R3";
    wr(32'h0000_0000); step();
    wr(32'h0100_0000); step();

    cur_req = "R5";
    wr(32'h0080_0000); pulse(7); step();
    step();

    cur_req = "R6";
    fifo_count = 16'd39; fifo_thresh = 16'd40; wr(32'h01FF_0000); step();
    step();
    fifo_count = 16'd41; fifo_thresh = 16'd40; step();
    fifo_push = 1; fifo_full = 0; wr(32'h01FF_0000); step();
    fifo_push = 0; fifo_full = 1; step();
    fifo_push = 1; fifo_full = 1; step();

    cur_req = "R9";
    wdog_bark = 1; step();
    wr(32'h0000_01FF); step();
    step();

    cur_req = "R7";
    wr(32'h81FF_0000, 4'b0111); step();
    wr(32'h0000_0000, 4'b1110); step();
    wr(32'h0000_0000, 4'b0000); step();

    cur_req = "R10";
    wr(32'h7E00_FE00); step();
    wr(32'hFFFF_FFFF, 4'b1011); step();

    cur_req = "R4";
    for (int i = 0; i < 9; i++) pulse(i);
    wdog_bark = 1; step();
    wr(rd_data); step();
    step();

    cur_req = "R2";
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) pulse($urandom_range(0, 8));
      if ($urandom_range(0, 15) == 0) wdog_bark = 1;
      if ($urandom_range(0, 4) == 0) begin
        if ($urandom_range(0, 1) == 0) wr(rd_data);
        else wr($urandom(), $urandom_range(0, 1) ? 4'hF : 4'($urandom()));
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule